// File: doc/BRIEF.md
# Flash Write-Status Polling Responder

This block stands in for the device side of a parallel NOR flash while an embedded program or erase runs. A single-cycle start pulse launches one of three operations: program one byte, erase a chosen set of sectors, or erase the whole array. A sector protect mask is sampled with the start pulse. While the operation is busy, reads at a status-valid address return a status byte instead of stored data. When the busy time ends, the block updates its small internal array and goes back to plain array reads.

Busy times are counted in clock cycles and set by parameters. A target that is entirely protected gets a shorter fixed window and leaves the array untouched. A separate cycle limit raises a sticky time-out flag. A host polls bit 7 of the returned byte until that bit matches the value it expects, then reads real data on the following cycle.

Top module: `flash_status_poll`

## Requirements
- R1: After reset, no operation is busy and every address reads 0x00.
- R2: A program is requested with op = 0. While it is busy, a read at the program address returns bit 7 = inverse of data bit 7, bit 3 = 0, and bits 4, 2, 1 and 0 = 0.
- R3: A program into an unprotected sector keeps status for exactly PROG_CYC cycles after the start edge. After that, the address reads the programmed byte.
- R4: A program into a protected sector keeps status for exactly PPROG_CYC cycles, and the array is left unchanged. A sector is the top SW bits of the address, and prot bit n covers sector n.
- R5: A sector erase is requested with op = 1 and mask cmd_sect. A chip erase is requested with op = 2 or 3 and selects all sectors. While the erase is busy, a read in any selected sector returns bit 7 = 0, bit 3 = 1, and bits 4, 2, 1 and 0 = 0.
- R6: An erase lasts ERASE_CYC cycles if any selected sector is unprotected, and PERASE_CYC cycles otherwise. When it ends, every byte of each selected unprotected sector reads 0xFF, and protected sectors keep their contents.
- R7: While busy, a read at an address that is not status-valid returns the stored array byte.
- R8: Bit 6 of the status byte inverts after every cycle in which rd is high during busy.
- R9: Bit 5 is set once an operation stays busy past LIMIT_CYC cycles. It then remains 1 in all later status reads until reset clears it.
- R10: A start pulse during busy is ignored. It does not change the running operation, its duration or the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch operation (ignored while busy) |
| op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| cmd_addr | input | AW | Program target address |
| cmd_data | input | 8 | Program data byte |
| cmd_sect | input | 2**SW | Sector-erase selection mask |
| prot | input | 2**SW | Per-sector protect mask, sampled at start |
| rd | input | 1 | Read strobe; toggles bit 6 while busy |
| rd_addr | input | AW | Read address |
| dout | output | 8 | Status byte or array byte |

## Verification
The hardest behaviour to reach is the mix of partial protection and the sticky time-out. It only appears after a long erase whose selection overlaps both protected and unprotected sectors, followed by further operations that must still report bit 5. The bench runs every non-empty erase mask against a fixed protect pattern after filling the array with distinct bytes, and shortens the busy counts so the first real erase crosses the limit. During every operation it also injects a conflicting start pulse and reads both status-valid and other addresses.

// File: rtl/flash_status_poll.sv
`timescale 1ns/1ps
module flash_status_poll #(
  parameter int AW         = 5,
  parameter int SW         = 2,
  parameter int CW         = 17,
  parameter int PROG_CYC   = 350,
  parameter int PPROG_CYC  = 100,
  parameter int ERASE_CYC  = 50000,
  parameter int PERASE_CYC = 5000,
  parameter int LIMIT_CYC  = 60000,
  localparam int NS        = 2**SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic [NS-1:0] cmd_sect,
  input  logic [NS-1:0] prot,
  input  logic          rd,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    dout
);
  localparam int DEPTH = 2**AW;
  localparam int OW    = AW - SW;

  logic [7:0]    mem [DEPTH];
  logic          busy, er, plive, tog, to;
  logic [AW-1:0] pa;
  logic [7:0]    pd;
  logic [NS-1:0] esel, eset;
  logic [CW-1:0] cnt, dur;

  logic [NS-1:0] sel_n;
  logic          live_n;
  logic [CW-1:0] dur_n;
  logic          valid;

  assign sel_n  = op[1] ? '1 : cmd_sect;
  assign live_n = (op == 2'd0) ? !prot[cmd_addr[AW-1 -: SW]] : |(sel_n & ~prot);
  assign dur_n  = (op == 2'd0) ? (live_n ? CW'(PROG_CYC)  : CW'(PPROG_CYC))
                               : (live_n ? CW'(ERASE_CYC) : CW'(PERASE_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      er    <= 1'b0;
      plive <= 1'b0;
      tog   <= 1'b0;
      to    <= 1'b0;
      pa    <= '0;
      pd    <= '0;
      esel  <= '0;
      eset  <= '0;
      cnt   <= '0;
      dur   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt   <= '0;
        er    <= (op != 2'd0);
        plive <= live_n;
        pa    <= cmd_addr;
        pd    <= cmd_data;
        esel  <= sel_n;
        eset  <= sel_n & ~prot;
        dur   <= dur_n;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (rd) tog <= ~tog;
      if (cnt == CW'(LIMIT_CYC)) to <= 1'b1;
      if (cnt == dur - 1'b1) begin
        busy <= 1'b0;
        if (!er && plive) mem[pa] <= pd;
        if (er)
          for (int i = 0; i < DEPTH; i++)
            if (eset[i >> OW]) mem[i] <= 8'hFF;
      end
    end
  end

  assign valid = er ? esel[rd_addr[AW-1 -: SW]] : (rd_addr == pa);
  assign dout  = (busy && valid) ? {er ? 1'b0 : ~pd[7], tog, to, 1'b0, er, 3'b000}
                                 : mem[rd_addr];

  p_prog_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !er && plive && cnt == dur - 1'b1 |=> mem[$past(pa)] == $past(pd));
  p_prot_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !er && !plive |=> mem[$past(pa)] == $past(mem[pa]));
  p_busy_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < dur);
  p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd |=> tog != $past(tog));
  p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    to |=> to);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(pa) && $stable(pd) && $stable(dur) && $stable(er));
endmodule

// File: tb/test_flash_status_poll.sv
`timescale 1ns/1ps
module test_flash_status_poll;
  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, rd = 1'b0;
  logic [1:0] op = '0;
  logic [4:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, dout;
  logic [3:0] cmd_sect = '0, prot = '0;
  logic [7:0] m [32];
  logic       to_exp = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_status_poll #(.AW(5), .SW(2), .CW(8), .PROG_CYC(6), .PPROG_CYC(3),
                      .ERASE_CYC(12), .PERASE_CYC(5), .LIMIT_CYC(8)) i_flash_status_poll (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sect(cmd_sect), .prot(prot), .rd(rd),
    .rd_addr(rd_addr), .dout(dout));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      rd_addr = 5'(i);
      #1 check(req, dout, m[i]);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic [4:0] a, input logic [7:0] d,
                        input logic [3:0] s);
    logic [3:0] es;
    logic       live, hasinv, t0;
    int         dur;
    logic [4:0] va, ia;
    logic [7:0] st;
    es = o[1] ? 4'hF : s;
    live = (o == 0) ? !prot[a[4:3]] : |(es & ~prot);
    dur = (o == 0) ? (live ? 6 : 3) : (live ? 12 : 5);
    va = a; ia = a ^ 5'd1; hasinv = 1'b1;
    if (o != 0) begin
      hasinv = 1'b0;
      for (int k = 3; k >= 0; k--) begin
        if (es[k]) va = 5'(k << 3);
        else begin ia = 5'(k << 3); hasinv = 1'b1; end
      end
    end
    st = {(o == 0) ? ~d[7] : 1'b0, 1'b0, to_exp, 1'b0, o != 0, 3'b000};
    @(negedge clk);
    op = o; cmd_addr = a; cmd_data = d; cmd_sect = s; start = 1'b1;
    @(negedge clk);
    // conflicting start while busy (R10)
    op = 2'd0; cmd_addr = a ^ 5'd5; cmd_data = ~d; rd = 1'b1; rd_addr = va;
    #1 check((o == 0) ? "R2 R9 status" : "R5 R9 status", dout & 8'hBF, st);
    t0 = dout[6];
    if (hasinv) begin
      rd_addr = ia;
      #1 check("R7 other address", dout, m[ia]);
      rd_addr = va;
    end
    @(negedge clk);
    start = 1'b0; rd = 1'b0;
    #1 check("R8 toggle", {7'd0, dout[6]}, {7'd0, ~t0});
    repeat (dur - 2) @(negedge clk);
    #1 check((o == 0) ? (live ? "R3 last busy" : "R4 last busy") : "R6 last busy",
             dout & 8'h9F, st & 8'h9F);
    if (o == 0) begin
      if (live) m[a] = d;
    end else begin
      for (int i = 0; i < 32; i++) if (es[i >> 3] && !prot[i >> 3]) m[i] = 8'hFF;
    end
    if (dur > 8) to_exp = 1'b1;
    @(negedge clk);
    #1 check((o == 0) ? (live ? "R3 done" : "R4 done") : "R6 done", dout, m[va]);
    check_all((o == 0) ? "R3 R4 R10 array" : "R6 R10 array");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");
    prot = 4'h0;
    for (int a = 0; a < 32; a++) run_op(2'd0, 5'(a), 8'(a * 37 + 1), 4'h0);
    prot = 4'hF;
    for (int a = 0; a < 32; a += 3) run_op(2'd0, 5'(a), 8'(a * 11 + 128), 4'h0);
    prot = 4'b0110;
    for (int s = 1; s < 16; s++) begin
      if (s == 9) begin
        prot = 4'h0;
        run_op(2'd0, 5'd1, 8'hC3, 4'h0);
        run_op(2'd0, 5'd30, 8'h17, 4'h0);
        prot = 4'b0110;
      end
      run_op(2'd1, 5'd0, 8'h00, 4'(s));
    end
    run_op(2'd2, 5'd0, 8'h00, 4'h0);
    prot = 4'hF;
    run_op(2'd3, 5'd0, 8'h00, 4'h0);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    to_exp = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 R9 after reset");
    prot = 4'h0;
    run_op(2'd0, 5'd9, 8'h5A, 4'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule